// File: doc/BRIEF.md
# Machine State Register Write Unit with Hypervisor Guard

This block holds the machine state register of a processor core and arbitrates the three ways it can be written. An ordinary move-to-register instruction may change any implemented bit except the hypervisor bit. A return-from-interrupt may change every implemented bit, including the hypervisor bit, and it also produces the realigned resume address. A direct-load port, driven by exception-entry logic outside the block, stores a ready-made value. Every stored value is first filtered through a per-core mask of implemented bits.

From the current register value the block continuously derives two things. The first is a two-bit memory-translation index: user, supervisor or hypervisor. The second is a packed context-flags word that the front end caches. When a move or a return flips either address-translation enable, a one-cycle flush-all request goes to the TLB. The register width is 32 or 64 bits. In a 64-bit build the hypervisor bit is bit 60. A 32-bit build places it at bit 29 when the hypervisor option is on, and has no hypervisor state at all when the option is off.

The write-source selection is the block's only state decision. It is an enumerated choice among four sources: none, move, return and load. The block has no multi-cycle sequence. Every transition is a single-edge register update chosen by that source.

Top module: `mstate_wr_unit`

## Requirements
- R1: Every stored value equals the written value ANDed with parameter IMPL_MASK, so `mstate` never has a bit set outside the mask.
- R2: On a move write (`mv_we`), the hypervisor bit keeps its current value whatever the written value holds.
- R3: On a return write (`ret_we`), the hypervisor bit takes the written value, subject to the mask.
- R4: The hypervisor bit is bit 60 when XLEN=64, and bit 29 when XLEN=32 and HYP32_EN=1. When XLEN=32 and HYP32_EN=0 there is no hypervisor state: bit 29 is an ordinary bit, `mem_idx` is never 2, and bit 29 is not part of the context mask.
- R5: `mem_idx` is 2 when the user bit (bit 14) is 0 and the hypervisor bit is 1. Otherwise it is 0 when the user bit is 1 and 1 when the user bit is 0.
- R6: `ctx_flags` equals `mstate` ANDed with a mask of bits 0, 9, 10, 13, 14, 22, 23, 25 and 31, plus bit 63 (64-bit builds) and the hypervisor bit (when present), then ORed with `side_flags`. It is combinational.
- R7: `flush_tlb` is high for exactly the cycle after a move or return edge whose masked value differs from the current register in bit 5 (instruction translation) or bit 4 (data translation), and low otherwise.
- R8: After a return edge, `redirect_vld` is high for one cycle with `redirect_pc` equal to `ret_pc` with bits 1:0 cleared.
- R9: A load write (`ld_we`) stores the masked value with the hypervisor bit as written. It never raises `flush_tlb` and never raises `redirect_vld`.
- R10: When several write enables are high in the same cycle, load wins over return and return wins over move. Only the winner's value and side effects apply.
- R11: After reset, `mstate` is bit 6 ANDed with IMPL_MASK, the hypervisor bit is 0, and `flush_tlb` and `redirect_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mv_we | input | 1 | Move-to-register write enable |
| mv_val | input | XLEN | Move-to-register value |
| ret_we | input | 1 | Return-from-interrupt write enable |
| ret_val | input | XLEN | Register value restored by the return |
| ret_pc | input | XLEN | Resume address of the return |
| ld_we | input | 1 | Direct-load write enable (exception entry) |
| ld_val | input | XLEN | Direct-load value |
| side_flags | input | XLEN | Flags from outside the register merged into the context word |
| mstate | output | XLEN | Current register value |
| mem_idx | output | 2 | Translation index: 0 user, 1 supervisor, 2 hypervisor |
| ctx_flags | output | XLEN | Packed context flags |
| flush_tlb | output | 1 | One-cycle flush-all-TLB request |
| redirect_vld | output | 1 | One-cycle valid for the return resume address |
| redirect_pc | output | XLEN | Word-aligned resume address |

## Verification
The bench builds three copies side by side from the same stimulus. The first is a 64-bit build with a mask that has holes at bits 1, 2, 3, 7 and 59. The second is a 32-bit build with the hypervisor option on. The third is a 32-bit build with the option off. Together they reach both hypervisor positions and the case where the bit is absent, where a return that sets bit 29 must still leave the index below the hypervisor level. The holes in the mask show that stores are filtered, and simultaneous enables show the source priority.

// File: rtl/mstate_wr_pkg.sv
package mstate_wr_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_MOVE   = 2'd1,
        SRC_RETURN = 2'd2,
        SRC_LOAD   = 2'd3
    } wr_src_e;

    localparam int BIT_LITTLE  = 0;
    localparam int BIT_DTRANS  = 4;
    localparam int BIT_ITRANS  = 5;
    localparam int BIT_VECBASE = 6;
    localparam int BIT_BRTRACE = 9;
    localparam int BIT_STEP    = 10;
    localparam int BIT_FPAVAIL = 13;
    localparam int BIT_USER    = 14;
    localparam int BIT_AUXA    = 22;
    localparam int BIT_AUXB    = 23;
    localparam int BIT_VECAV   = 25;
    localparam int BIT_HYP32   = 29;
    localparam int BIT_COMP32  = 31;
    localparam int BIT_HYP64   = 60;
    localparam int BIT_WIDE    = 63;

    function automatic int hyp_pos(input int xlen);
        return (xlen == 64) ? BIT_HYP64 : BIT_HYP32;
    endfunction

    function automatic logic [63:0] ctx_mask(input int xlen, input bit hyp_on);
        logic [63:0] m;
        m = '0;
        m[BIT_LITTLE]  = 1'b1;
        m[BIT_BRTRACE] = 1'b1;
        m[BIT_STEP]    = 1'b1;
        m[BIT_FPAVAIL] = 1'b1;
        m[BIT_USER]    = 1'b1;
        m[BIT_AUXA]    = 1'b1;
        m[BIT_AUXB]    = 1'b1;
        m[BIT_VECAV]   = 1'b1;
        m[BIT_COMP32]  = 1'b1;
        if (xlen == 64) m[BIT_WIDE] = 1'b1;
        if (hyp_on)     m[hyp_pos(xlen)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mstate_src_sel.sv
module mstate_src_sel
    import mstate_wr_pkg::*;
#(
    parameter int               XLEN    = 64,
    parameter logic [XLEN-1:0]  MASK    = '1,
    parameter logic [XLEN-1:0]  HYP_BIT = '0
) (
    input  logic [XLEN-1:0] cur,
    input  logic            mv_we,
    input  logic [XLEN-1:0] mv_val,
    input  logic            ret_we,
    input  logic [XLEN-1:0] ret_val,
    input  logic            ld_we,
    input  logic [XLEN-1:0] ld_val,
    output wr_src_e         src,
    output logic [XLEN-1:0] nxt,
    output logic            flush_req
);

    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] masked;

    // Fixed priority: exception load, then return, then move.
    always_comb begin
        if (ld_we)       src = SRC_LOAD;
        else if (ret_we) src = SRC_RETURN;
        else if (mv_we)  src = SRC_MOVE;
        else             src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_LOAD:   raw = ld_val;
            SRC_RETURN: raw = ret_val;
            SRC_MOVE:   raw = mv_val;
            default:    raw = cur;
        endcase
        masked = raw & MASK;
        // A move cannot touch the hypervisor bit.
        if (src == SRC_MOVE)
            nxt = (masked & ~HYP_BIT) | (cur & HYP_BIT);
        else
            nxt = masked;
    end

    always_comb begin
        flush_req = 1'b0;
        if (src == SRC_MOVE || src == SRC_RETURN)
            flush_req = (nxt[BIT_ITRANS] != cur[BIT_ITRANS]) ||
                        (nxt[BIT_DTRANS] != cur[BIT_DTRANS]);
    end

endmodule

// File: rtl/mstate_derive.sv
module mstate_derive
    import mstate_wr_pkg::*;
#(
    parameter int               XLEN     = 64,
    parameter logic [XLEN-1:0]  HYP_BIT  = '0,
    parameter logic [XLEN-1:0]  CTX_MASK = '0
) (
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] side_flags,
    output logic [1:0]      mem_idx,
    output logic [XLEN-1:0] ctx_flags
);

    logic user_mode;
    logic hyp_mode;

    always_comb begin
        user_mode = cur[BIT_USER];
        hyp_mode  = |(cur & HYP_BIT);
        if (!user_mode && hyp_mode) mem_idx = 2'd2;
        else if (user_mode)         mem_idx = 2'd0;
        else                        mem_idx = 2'd1;
        ctx_flags = (cur & CTX_MASK) | side_flags;
    end

endmodule

// File: rtl/mstate_wr_unit.sv
module mstate_wr_unit
    import mstate_wr_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter bit          HYP32_EN  = 1'b1,
    parameter logic [63:0] IMPL_MASK = 64'hF7FF_FFFF_FFFF_FF71
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mv_we,
    input  logic [XLEN-1:0] mv_val,
    input  logic            ret_we,
    input  logic [XLEN-1:0] ret_val,
    input  logic [XLEN-1:0] ret_pc,
    input  logic            ld_we,
    input  logic [XLEN-1:0] ld_val,
    input  logic [XLEN-1:0] side_flags,
    output logic [XLEN-1:0] mstate,
    output logic [1:0]      mem_idx,
    output logic [XLEN-1:0] ctx_flags,
    output logic            flush_tlb,
    output logic            redirect_vld,
    output logic [XLEN-1:0] redirect_pc
);

    localparam bit              HYP_ON   = (XLEN == 64) || HYP32_EN;
    localparam int              HYP_POS  = hyp_pos(XLEN);
    localparam logic [XLEN-1:0] MASK     = IMPL_MASK[XLEN-1:0];
    localparam logic [XLEN-1:0] HYP_BIT  = HYP_ON ? (XLEN'(1) << HYP_POS) : '0;
    localparam logic [63:0]     CTX64    = ctx_mask(XLEN, HYP_ON);
    localparam logic [XLEN-1:0] CTX_MASK = CTX64[XLEN-1:0];
    localparam logic [XLEN-1:0] RST_VAL  = (XLEN'(1) << BIT_VECBASE) & MASK & ~HYP_BIT;
    localparam logic [XLEN-1:0] PC_ALIGN = ~XLEN'(3);

    wr_src_e         src;
    logic [XLEN-1:0] nxt;
    logic            flush_req;
    logic [XLEN-1:0] mstate_q;
    logic            flush_q;
    logic            redir_vld_q;
    logic [XLEN-1:0] redir_pc_q;

    mstate_src_sel #(
        .XLEN    (XLEN),
        .MASK    (MASK),
        .HYP_BIT (HYP_BIT)
    ) u_sel (
        .cur       (mstate_q),
        .mv_we     (mv_we),
        .mv_val    (mv_val),
        .ret_we    (ret_we),
        .ret_val   (ret_val),
        .ld_we     (ld_we),
        .ld_val    (ld_val),
        .src       (src),
        .nxt       (nxt),
        .flush_req (flush_req)
    );

    mstate_derive #(
        .XLEN     (XLEN),
        .HYP_BIT  (HYP_BIT),
        .CTX_MASK (CTX_MASK)
    ) u_derive (
        .cur        (mstate_q),
        .side_flags (side_flags),
        .mem_idx    (mem_idx),
        .ctx_flags  (ctx_flags)
    );

    // State register: the update is chosen by the write source.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mstate_q    <= RST_VAL;
            flush_q     <= 1'b0;
            redir_vld_q <= 1'b0;
            redir_pc_q  <= '0;
        end else begin
            unique case (src)
                SRC_NONE: begin
                    flush_q     <= 1'b0;
                    redir_vld_q <= 1'b0;
                end
                SRC_MOVE: begin
                    mstate_q    <= nxt;
                    flush_q     <= flush_req;
                    redir_vld_q <= 1'b0;
                end
                SRC_RETURN: begin
                    mstate_q    <= nxt;
                    flush_q     <= flush_req;
                    redir_vld_q <= 1'b1;
                    redir_pc_q  <= ret_pc & PC_ALIGN;
                end
                SRC_LOAD: begin
                    mstate_q    <= nxt;
                    flush_q     <= 1'b0;
                    redir_vld_q <= 1'b0;
                end
                default: begin
                    flush_q     <= 1'b0;
                    redir_vld_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        mstate       = mstate_q;
        flush_tlb    = flush_q;
        redirect_vld = redir_vld_q;
        redirect_pc  = redir_pc_q;
    end

    // R1: no bit outside the implemented mask is ever stored
    p_impl_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mstate_q & ~MASK) == '0);

    // R5: index encoding has only three legal values
    p_idx_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_idx != 2'd3);

    // R7: a flush pulse always follows a change of a translation enable
    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> (mstate_q[BIT_ITRANS:BIT_DTRANS] != $past(mstate_q[BIT_ITRANS:BIT_DTRANS])));

    // R8: the resume address is word aligned
    p_pc_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld_q |-> (redir_pc_q[1:0] == 2'b00));

    // R9: a load never requests a flush or a redirect
    p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (!flush_q && !redir_vld_q));

    generate
        if (HYP_ON) begin : g_hyp_chk
            // R2: a move alone leaves the hypervisor bit unchanged
            p_hyp_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (mv_we && !ret_we && !ld_we) |=> $stable(mstate_q[HYP_POS]));
        end else begin : g_nohyp_chk
            // R4: without hypervisor state the top index is unreachable
            p_no_hyp_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
                mem_idx != 2'd2);
        end
    endgenerate

endmodule

// File: tb/mstate_wr_unit_tb_top.sv
module mstate_wr_unit_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] M64 = 64'hF7FF_FFFF_FFFF_FF71;
    localparam logic [63:0] M32 = 64'h0000_0000_FFFF_FFF1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        mv_we = 0, ret_we = 0, ld_we = 0;
    logic [63:0] mv_val = '0, ret_val = '0, ret_pc = '0, ld_val = '0, side = '0;

    logic [63:0] st64, cf64, rp64;
    logic [31:0] st32, cf32, rp32, st32n, cf32n, rp32n;
    logic [1:0]  ix64, ix32, ix32n;
    logic        fl64, fl32, fl32n, rv64, rv32, rv32n;

    mstate_wr_unit #(.XLEN(64), .HYP32_EN(1'b1), .IMPL_MASK(M64)) dut_i (
        .clk(clk), .rst_n(rst_n), .mv_we(mv_we), .mv_val(mv_val),
        .ret_we(ret_we), .ret_val(ret_val), .ret_pc(ret_pc),
        .ld_we(ld_we), .ld_val(ld_val), .side_flags(side),
        .mstate(st64), .mem_idx(ix64), .ctx_flags(cf64), .flush_tlb(fl64),
        .redirect_vld(rv64), .redirect_pc(rp64));

    mstate_wr_unit #(.XLEN(32), .HYP32_EN(1'b1), .IMPL_MASK(M32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .mv_we(mv_we), .mv_val(mv_val[31:0]),
        .ret_we(ret_we), .ret_val(ret_val[31:0]), .ret_pc(ret_pc[31:0]),
        .ld_we(ld_we), .ld_val(ld_val[31:0]), .side_flags(side[31:0]),
        .mstate(st32), .mem_idx(ix32), .ctx_flags(cf32), .flush_tlb(fl32),
        .redirect_vld(rv32), .redirect_pc(rp32));

    mstate_wr_unit #(.XLEN(32), .HYP32_EN(1'b0), .IMPL_MASK(M32)) dut32n_i (
        .clk(clk), .rst_n(rst_n), .mv_we(mv_we), .mv_val(mv_val[31:0]),
        .ret_we(ret_we), .ret_val(ret_val[31:0]), .ret_pc(ret_pc[31:0]),
        .ld_we(ld_we), .ld_val(ld_val[31:0]), .side_flags(side[31:0]),
        .mstate(st32n), .mem_idx(ix32n), .ctx_flags(cf32n), .flush_tlb(fl32n),
        .redirect_vld(rv32n), .redirect_pc(rp32n));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state: [0] 64-bit, [1] 32-bit with hyp, [2] 32-bit no hyp
    logic [63:0] em [3];
    logic        ef [3];
    logic        erv;
    logic [63:0] erp;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_of(input int k);
        return (k == 0) ? M64 : M32;
    endfunction

    function automatic int hpos_of(input int k);
        return (k == 0) ? 60 : 29;
    endfunction

    function automatic bit hon_of(input int k);
        return (k != 2);
    endfunction

    function automatic logic [1:0] idx_model(input int k, input logic [63:0] m);
        logic hv;
        hv = hon_of(k) ? m[hpos_of(k)] : 1'b0;
        if (!m[14] && hv) return 2'd2;
        return m[14] ? 2'd0 : 2'd1;
    endfunction

    function automatic logic [63:0] ctx_model(input int k, input logic [63:0] m);
        logic [63:0] cm;
        cm = 64'h0000_0000_82C0_6601;
        if (k == 0) cm[63] = 1'b1;
        if (hon_of(k)) cm[hpos_of(k)] = 1'b1;
        if (k != 0) return ((m & cm) | side) & 64'hFFFF_FFFF;
        return (m & cm) | side;
    endfunction

    // src: 0 none, 1 move, 2 return, 3 load
    task automatic model_step(input int src, input logic [63:0] d, input logic [63:0] pc);
        for (int k = 0; k < 3; k++) begin
            logic [63:0] v;
            v = d & mask_of(k);
            if (src == 0) v = em[k];
            if (src == 1 && hon_of(k)) v[hpos_of(k)] = em[k][hpos_of(k)];
            ef[k] = (src == 1 || src == 2) && (v[5:4] != em[k][5:4]);
            em[k] = v;
        end
        erv = (src == 2);
        if (src == 2) erp = pc & ~64'h3;
    endtask

    task automatic check_all(input string tag);
        chk(tag, "state64", st64, em[0]);
        chk(tag, "state32", {32'h0, st32}, em[1]);
        chk(tag, "state32n", {32'h0, st32n}, em[2]);
        chk(tag, "idx64", {62'h0, ix64}, {62'h0, idx_model(0, em[0])});
        chk(tag, "idx32", {62'h0, ix32}, {62'h0, idx_model(1, em[1])});
        chk(tag, "idx32n", {62'h0, ix32n}, {62'h0, idx_model(2, em[2])});
        chk(tag, "ctx64", cf64, ctx_model(0, em[0]));
        chk(tag, "ctx32", {32'h0, cf32}, ctx_model(1, em[1]));
        chk(tag, "ctx32n", {32'h0, cf32n}, ctx_model(2, em[2]));
        chk(tag, "flush64", {63'h0, fl64}, {63'h0, ef[0]});
        chk(tag, "flush32", {63'h0, fl32}, {63'h0, ef[1]});
        chk(tag, "flush32n", {63'h0, fl32n}, {63'h0, ef[2]});
        chk(tag, "redir_vld", {63'h0, rv64}, {63'h0, erv});
        if (erv) chk(tag, "redir_pc", rp64, erp);
    endtask

    // Called at a negative edge: drive, pass one rising edge, return at the next negative edge.
    task automatic step(input bit m, input bit r, input bit l,
                        input logic [63:0] mv, input logic [63:0] rv,
                        input logic [63:0] lv, input logic [63:0] pc);
        int src;
        mv_we = m; ret_we = r; ld_we = l;
        mv_val = mv; ret_val = rv; ld_val = lv; ret_pc = pc;
        src = l ? 3 : (r ? 2 : (m ? 1 : 0));
        model_step(src, l ? lv : (r ? rv : mv), pc);
        @(negedge clk);
        mv_we = 0; ret_we = 0; ld_we = 0;
    endtask

    task automatic t_reset;
        for (int k = 0; k < 3; k++) begin em[k] = 64'h40; ef[k] = 0; end
        erv = 0; erp = '0;
        check_all("R11");
    endtask

    task automatic t_move_mask;
        step(1, 0, 0, '1, '0, '0, '0);
        check_all("R1");
        chk("R1", "hole bits64", st64 & ~M64, 64'h0);
        chk("R7", "flush on enable change", {63'h0, fl64}, 64'h1);
        step(0, 0, 0, '0, '0, '0, '0);
        check_all("R7");
    endtask

    task automatic t_move_hyp;
        step(1, 0, 0, ~(64'h1 << 14), '0, '0, '0);
        check_all("R2");
        chk("R2", "hyp64 kept 0", {63'h0, st64[60]}, 64'h0);
        chk("R7", "no flush when enables equal", {63'h0, fl64}, 64'h0);
    endtask

    task automatic t_return;
        side = 64'h0000_0000_0004_0002;
        step(0, 1, 0, '0, ~(64'h1 << 14), '0, 64'h1234_5678_9ABC_DEF7);
        check_all("R3");
        chk("R5", "idx64 hypervisor", {62'h0, ix64}, 64'd2);
        chk("R4", "idx32 hyp at bit29", {62'h0, ix32}, 64'd2);
        chk("R4", "idx32n no hyp", {62'h0, ix32n}, 64'd1);
        chk("R8", "redirect pc", rp64, 64'h1234_5678_9ABC_DEF4);
        chk("R6", "ctx64", cf64, ctx_model(0, em[0]));
        step(0, 0, 0, '0, '0, '0, '0);
        check_all("R8");
    endtask

    task automatic t_move_clear;
        step(1, 0, 0, '0, '0, '0, '0);
        check_all("R2");
        chk("R2", "hyp64 kept 1", {63'h0, st64[60]}, 64'h1);
        chk("R5", "idx64 stays hyp", {62'h0, ix64}, 64'd2);
    endtask

    task automatic t_user_hyp;
        side = 64'h8000_0000_0000_0000;
        step(0, 1, 0, '0, 64'h1000_0000_2000_4000, '0, 64'h11);
        check_all("R5");
        chk("R5", "user wins over hyp", {62'h0, ix64}, 64'd0);
        chk("R6", "ctx side merge", cf64, ctx_model(0, em[0]));
    endtask

    task automatic t_load;
        step(0, 0, 1, '0, '0, 64'h0000_0000_0000_0030, '0);
        check_all("R9");
        chk("R9", "no flush on load", {63'h0, fl64}, 64'h0);
        chk("R9", "hyp cleared by load", {63'h0, st64[60]}, 64'h0);
        step(0, 0, 1, '0, '0, 64'h1000_0000_0000_0030, '0);
        check_all("R9");
        chk("R9", "hyp set by load", {63'h0, st64[60]}, 64'h1);
    endtask

    task automatic t_priority;
        side = '0;
        step(1, 1, 1, 64'hFFFF, 64'h4000, 64'h0000_0000_0000_2001, 64'h40);
        check_all("R10");
        chk("R10", "load value wins", st64, 64'h2001);
        step(1, 1, 0, 64'h0000_0000_0000_4030, 64'h0000_0000_0000_0010, '0, 64'h103);
        check_all("R10");
        chk("R10", "return beats move", st64, 64'h10);
        chk("R10", "return redirect", {63'h0, rv64}, 64'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_move_mask();
        t_move_hyp();
        t_return();
        t_move_clear();
        t_user_hyp();
        t_load();
        t_priority();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule